// File: doc/BRIEF.md
# Save Writeback Sequencer

This block copies a console's emulated save memory back to non-volatile storage after the player presses and releases the console's reset button. That button action produces a non-maskable interrupt (NMI) on the cartridge slot. The sequencer samples the NMI line through a two-flop synchronizer. When it sees a rising edge, it reads the active save-type code and checks that the cartridge is not in development mode. If the type calls for a writeback, it captures the source, the sector count and the base address, and then walks a table of sector addresses, one sector at a time.

For each sector it reads entry `i` of the sector-address table, which is a synchronous RAM with one cycle of read latency. It then fetches one sector of 16-bit words from one of two sources. For EEPROM save types the source is an on-chip EEPROM image, also a synchronous RAM with one cycle of latency. For SRAM and Flash save types the source is a fixed SDRAM region, read through a request/acknowledge port. Each word is streamed out over a valid/ready port that carries the sector address. After the last word the sequencer waits for the storage side to report that the sector is committed. `busy_o` covers the whole run.

Top module: `save_flush_seq`

## Requirements
- R1: A rising edge on `nmi_i` starts a run. `busy_o` goes high after exactly the third rising clock edge that samples `nmi_i` high (two-flop synchronizer, then the state register).
- R2: No run starts while `dev_mode_i` is 1, or when `save_type_i` is 0, 6 or 7. In these cases `busy_o` stays low and no write beat appears.
- R3: The number of sectors written per run depends on the save type: 1 for type 1 (4 Kbit EEPROM), 4 for type 2 (16 Kbit EEPROM), 64 for type 3 (256 Kbit SRAM), 256 for type 4 (1 Mbit Flash) and 192 for type 5 (768 Kbit SRAM).
- R4: Sector `i` of a run reads table entry `i`. While that sector is written, `sec_lba_o` equals bits 26:0 of the entry; bits 31:27 are discarded.
- R5: For types 1 and 2, word `w` of sector `i` is the EEPROM image word at address `i*SECTOR_WORDS + w`.
- R6: For types 3 and 5, word `w` of sector `i` is the SDRAM word at `0x1FFC000 + i*SECTOR_WORDS + w`. For type 4 the base is `0x1FF0000`. Each request holds its address until it is acknowledged.
- R7: Each sector is exactly `SECTOR_WORDS` accepted beats. `sec_last_o` is high only on the final beat, and a beat stays unchanged while `sec_valid_o` is high and `sec_ready_i` is low.
- R8: `busy_o` stays high until `sec_done_i` acknowledges the final sector, and goes low on the next clock edge.
- R9: An NMI edge during a run is ignored. The save type and development mode are captured at the start, so later changes to them do not alter the run in progress.
- R10: After reset, `busy_o`, `sec_valid_o` and `sdr_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_i | input | 1 | Console NMI, asynchronous |
| save_type_i | input | 3 | Active save-type code |
| dev_mode_i | input | 1 | Development mode, suppresses writeback |
| tbl_idx_o | output | 8 | Sector table read index |
| tbl_entry_i | input | 32 | Table entry, one cycle after index |
| eep_addr_o | output | 10 | EEPROM image word address |
| eep_word_i | input | 16 | EEPROM image word, one cycle after address |
| sdr_req_o | output | 1 | SDRAM word read request |
| sdr_addr_o | output | 26 | SDRAM word address |
| sdr_ack_i | input | 1 | SDRAM request accepted, data valid |
| sdr_word_i | input | 16 | SDRAM read data |
| sec_lba_o | output | 27 | Sector address of the current write |
| sec_valid_o | output | 1 | Write beat valid |
| sec_word_o | output | 16 | Write beat data |
| sec_last_o | output | 1 | Final beat of sector |
| sec_ready_i | input | 1 | Storage accepts beat |
| sec_done_i | input | 1 | Sector committed |
| busy_o | output | 1 | Writeback run in progress |

## Verification
`busy_o` is due exactly three clock edges after NMI is driven high just after a falling edge. The bench samples it at the falling edge after the second rising edge, expecting it low, and again after the third, expecting it high. Every beat is scored at the falling edge before the rising edge that accepts it, using the ready value the bench has just driven. Expected words come from address-derived functions, so table, EEPROM and SDRAM latency never enters the expected values. The end of a run is checked one edge after `sec_done_i` is presented: `busy_o` must be high while the acknowledge is pending and low at the next falling edge.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [2:0] {
        KIND_NONE     = 3'd0,
        KIND_EEP_4K   = 3'd1,
        KIND_EEP_16K  = 3'd2,
        KIND_SRAM_256 = 3'd3,
        KIND_FLASH_1M = 3'd4,
        KIND_SRAM_768 = 3'd5
    } save_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TBL_ADDR,
        PH_TBL_CAP,
        PH_FETCH,
        PH_EEP_CAP,
        PH_PUSH,
        PH_COMMIT
    } phase_e;

endpackage

// File: rtl/sfs_nmi_sync.sv
module sfs_nmi_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.s1   = nmi_i;
        sync_d.s2   = sync_q.s1;
        sync_d.prev = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.prev;
endmodule

// File: rtl/sfs_kind_decode.sv
module sfs_kind_decode #(
    parameter int CNT_W       = 9,
    parameter int SDR_AW      = 26,
    parameter logic [SDR_AW-1:0] SRAM_BASE  = 26'h1FFC000,
    parameter logic [SDR_AW-1:0] FLASH_BASE = 26'h1FF0000,
    parameter int SECT_EEP4   = 1,
    parameter int SECT_EEP16  = 4,
    parameter int SECT_SRAM   = 64,
    parameter int SECT_FLASH  = 256,
    parameter int SECT_SRAM3  = 192
) (
    input  logic [2:0]        kind_i,
    input  logic              dev_i,
    output logic              enable_o,
    output logic              use_eep_o,
    output logic [CNT_W-1:0]  nsect_o,
    output logic [SDR_AW-1:0] base_o
);
    import sfs_pkg::*;

    always_comb begin
        enable_o  = 1'b1;
        use_eep_o = 1'b0;
        nsect_o   = '0;
        base_o    = SRAM_BASE;
        case (kind_i)
            KIND_EEP_4K: begin
                use_eep_o = 1'b1;
                nsect_o   = CNT_W'(SECT_EEP4);
            end
            KIND_EEP_16K: begin
                use_eep_o = 1'b1;
                nsect_o   = CNT_W'(SECT_EEP16);
            end
            KIND_SRAM_256: nsect_o = CNT_W'(SECT_SRAM);
            KIND_FLASH_1M: begin
                nsect_o = CNT_W'(SECT_FLASH);
                base_o  = FLASH_BASE;
            end
            KIND_SRAM_768: nsect_o = CNT_W'(SECT_SRAM3);
            default:       enable_o = 1'b0;
        endcase
        if (dev_i) enable_o = 1'b0;
    end
endmodule

// File: rtl/sfs_addr_gen.sv
module sfs_addr_gen #(
    parameter int IDX_W  = 8,
    parameter int WORD_W = 8,
    parameter int EEP_AW = 10,
    parameter int SDR_AW = 26
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [SDR_AW-1:0] base_i,
    output logic [EEP_AW-1:0] eep_addr_o,
    output logic [SDR_AW-1:0] sdr_addr_o
);
    localparam int OFF_W = IDX_W + WORD_W;

    logic [OFF_W-1:0] off;
    assign off = {idx_i, word_i};

    generate
        if (OFF_W >= EEP_AW) begin : g_eep_trunc
            assign eep_addr_o = off[EEP_AW-1:0];
        end else begin : g_eep_ext
            assign eep_addr_o = {{(EEP_AW-OFF_W){1'b0}}, off};
        end
        if (OFF_W >= SDR_AW) begin : g_sdr_trunc
            assign sdr_addr_o = base_i + off[SDR_AW-1:0];
        end else begin : g_sdr_ext
            assign sdr_addr_o = base_i + {{(SDR_AW-OFF_W){1'b0}}, off};
        end
    endgenerate
endmodule

// File: rtl/save_flush_seq.sv
module save_flush_seq #(
    parameter int SECTOR_WORDS = 256,
    parameter int TBL_DEPTH    = 256,
    parameter int TBL_W        = 32,
    parameter int LBA_W        = 27,
    parameter int EEP_AW       = 10,
    parameter int SDR_AW       = 26,
    parameter int DATA_W       = 16,
    parameter logic [SDR_AW-1:0] SRAM_BASE  = 26'h1FFC000,
    parameter logic [SDR_AW-1:0] FLASH_BASE = 26'h1FF0000,
    parameter int SECT_EEP4    = 1,
    parameter int SECT_EEP16   = 4,
    parameter int SECT_SRAM    = 64,
    parameter int SECT_FLASH   = 256,
    parameter int SECT_SRAM3   = 192,
    localparam int IDX_W       = $clog2(TBL_DEPTH),
    localparam int WORD_W      = $clog2(SECTOR_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_i,
    input  logic [2:0]        save_type_i,
    input  logic              dev_mode_i,
    output logic [IDX_W-1:0]  tbl_idx_o,
    input  logic [TBL_W-1:0]  tbl_entry_i,
    output logic [EEP_AW-1:0] eep_addr_o,
    input  logic [DATA_W-1:0] eep_word_i,
    output logic              sdr_req_o,
    output logic [SDR_AW-1:0] sdr_addr_o,
    input  logic              sdr_ack_i,
    input  logic [DATA_W-1:0] sdr_word_i,
    output logic [LBA_W-1:0]  sec_lba_o,
    output logic              sec_valid_o,
    output logic [DATA_W-1:0] sec_word_o,
    output logic              sec_last_o,
    input  logic              sec_ready_i,
    input  logic              sec_done_i,
    output logic              busy_o
);
    import sfs_pkg::*;

    localparam int CNT_W = IDX_W + 1;
    localparam logic [WORD_W-1:0] WORD_MAX = WORD_W'(SECTOR_WORDS - 1);

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic [WORD_W-1:0]   word;
        logic [LBA_W-1:0]    lba;
        logic                use_eep;
        logic [CNT_W-1:0]    nsect;
        logic [SDR_AW-1:0]   base;
        logic [DATA_W-1:0]   data;
    } seq_t;

    seq_t seq_d, seq_q;

    logic              nmi_rise;
    logic              kind_en;
    logic              kind_eep;
    logic [CNT_W-1:0]  kind_nsect;
    logic [SDR_AW-1:0] kind_base;
    logic              word_end;
    logic              run_end;

    sfs_nmi_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .rise_o (nmi_rise)
    );

    sfs_kind_decode #(
        .CNT_W      (CNT_W),
        .SDR_AW     (SDR_AW),
        .SRAM_BASE  (SRAM_BASE),
        .FLASH_BASE (FLASH_BASE),
        .SECT_EEP4  (SECT_EEP4),
        .SECT_EEP16 (SECT_EEP16),
        .SECT_SRAM  (SECT_SRAM),
        .SECT_FLASH (SECT_FLASH),
        .SECT_SRAM3 (SECT_SRAM3)
    ) u_decode (
        .kind_i    (save_type_i),
        .dev_i     (dev_mode_i),
        .enable_o  (kind_en),
        .use_eep_o (kind_eep),
        .nsect_o   (kind_nsect),
        .base_o    (kind_base)
    );

    sfs_addr_gen #(
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W),
        .EEP_AW (EEP_AW),
        .SDR_AW (SDR_AW)
    ) u_addr (
        .idx_i      (seq_q.idx),
        .word_i     (seq_q.word),
        .base_i     (seq_q.base),
        .eep_addr_o (eep_addr_o),
        .sdr_addr_o (sdr_addr_o)
    );

    assign word_end = (seq_q.word == WORD_MAX);
    assign run_end  = (({1'b0, seq_q.idx} + CNT_W'(1)) == seq_q.nsect);

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (nmi_rise && kind_en) begin
                    seq_d.idx     = '0;
                    seq_d.word    = '0;
                    seq_d.use_eep = kind_eep;
                    seq_d.nsect   = kind_nsect;
                    seq_d.base    = kind_base;
                    seq_d.phase   = PH_TBL_ADDR;
                end
            end
            PH_TBL_ADDR: seq_d.phase = PH_TBL_CAP;
            PH_TBL_CAP: begin
                seq_d.lba   = tbl_entry_i[LBA_W-1:0];
                seq_d.word  = '0;
                seq_d.phase = PH_FETCH;
            end
            PH_FETCH: begin
                if (seq_q.use_eep) begin
                    seq_d.phase = PH_EEP_CAP;
                end else if (sdr_ack_i) begin
                    seq_d.data  = sdr_word_i;
                    seq_d.phase = PH_PUSH;
                end
            end
            PH_EEP_CAP: begin
                seq_d.data  = eep_word_i;
                seq_d.phase = PH_PUSH;
            end
            PH_PUSH: begin
                if (sec_ready_i) begin
                    if (word_end) begin
                        seq_d.phase = PH_COMMIT;
                    end else begin
                        seq_d.word  = seq_q.word + WORD_W'(1);
                        seq_d.phase = PH_FETCH;
                    end
                end
            end
            PH_COMMIT: begin
                if (sec_done_i) begin
                    if (run_end) begin
                        seq_d.phase = PH_IDLE;
                    end else begin
                        seq_d.idx   = seq_q.idx + IDX_W'(1);
                        seq_d.phase = PH_TBL_ADDR;
                    end
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{phase: PH_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign tbl_idx_o   = seq_q.idx;
    assign sdr_req_o   = (seq_q.phase == PH_FETCH) && !seq_q.use_eep;
    assign sec_lba_o   = seq_q.lba;
    assign sec_valid_o = (seq_q.phase == PH_PUSH);
    assign sec_word_o  = seq_q.data;
    assign sec_last_o  = (seq_q.phase == PH_PUSH) && word_end;
    assign busy_o      = (seq_q.phase != PH_IDLE);
endmodule

// File: rtl/save_flush_seq_chk.sv
module save_flush_seq_chk #(
    parameter int DATA_W = 16,
    parameter int SDR_AW = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              nmi_i,
    input logic              busy_o,
    input logic              sec_valid_o,
    input logic              sec_ready_i,
    input logic [DATA_W-1:0] sec_word_o,
    input logic              sec_last_o,
    input logic              sdr_req_o,
    input logic              sdr_ack_i,
    input logic [SDR_AW-1:0] sdr_addr_o
);
    AST_START_AFTER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(nmi_i, 3)); // R1

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid_o && !sec_ready_i |=> sec_valid_o && $stable(sec_word_o) && $stable(sec_last_o)); // R7

    AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        sec_last_o |-> sec_valid_o); // R7

    AST_SDR_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sdr_req_o && !sdr_ack_i |=> sdr_req_o && $stable(sdr_addr_o)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sec_valid_o && !sdr_req_o); // R10

    AST_BUSY_COVERS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid_o |-> busy_o); // R8
endmodule

bind save_flush_seq save_flush_seq_chk #(.DATA_W(DATA_W), .SDR_AW(SDR_AW)) u_chk (.*);

// File: tb/save_flush_seq_test.sv
`timescale 1ns/1ps
module save_flush_seq_test;
    localparam int SW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_i = 1'b0;
    logic [2:0]  save_type_i = 3'd0;
    logic        dev_mode_i = 1'b0;
    logic [7:0]  tbl_idx_o;
    logic [31:0] tbl_entry_i = '0;
    logic [9:0]  eep_addr_o;
    logic [15:0] eep_word_i = '0;
    logic        sdr_req_o;
    logic [25:0] sdr_addr_o;
    logic        sdr_ack_i = 1'b0;
    logic [15:0] sdr_word_i = '0;
    logic [26:0] sec_lba_o;
    logic        sec_valid_o;
    logic [15:0] sec_word_o;
    logic        sec_last_o;
    logic        sec_ready_i = 1'b0;
    logic        sec_done_i = 1'b0;
    logic        busy_o;

    save_flush_seq #(.SECTOR_WORDS(SW)) uut (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] eep_f(input logic [9:0] a);
        return {6'b0, a} ^ 16'h5A5A;
    endfunction
    function automatic logic [15:0] sdr_f(input logic [25:0] a);
        return a[15:0] ^ {6'b0, a[25:16]} ^ 16'h3C3C;
    endfunction
    function automatic logic [31:0] tbl_f(input logic [7:0] i);
        return {i[4:0] ^ 5'h15, 27'(32'(i) * 32'd40009 + 32'd77)};
    endfunction
    function automatic int exp_count(input int kind, input bit dev);
        if (dev) return 0;
        case (kind)
            1: return 1;
            2: return 4;
            3: return 64;
            4: return 256;
            5: return 192;
            default: return 0;
        endcase
    endfunction

    // synchronous-read memories, one cycle of latency
    always @(posedge clk) begin
        eep_word_i  <= eep_f(eep_addr_o);
        tbl_entry_i <= tbl_f(tbl_idx_o);
    end

    int  exp_kind   = 0;
    int  exp_sect   = 0;
    int  sec_seen   = 0;
    int  beat       = 0;
    int  sec_bad    = 0;
    int  done_wait  = 0;
    int  wcnt       = 0;
    int  rcyc       = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            // SDRAM responder
            if (sdr_ack_i) begin
                sdr_ack_i = 1'b0;
                wcnt = 0;
            end else if (sdr_req_o) begin
                if (wcnt >= int'(sdr_addr_o[1:0])) begin
                    sdr_ack_i  = 1'b1;
                    sdr_word_i = sdr_f(sdr_addr_o);
                end else begin
                    wcnt++;
                end
            end
            // commit acknowledge
            if (sec_done_i) begin
                sec_done_i = 1'b0;
                if (sec_seen == exp_sect)
                    check(busy_o == 1'b0, "R8 busy low after final commit", busy_o, 0);
                else
                    check(busy_o == 1'b1, "R8 busy held between sectors", busy_o, 1);
            end else if (done_wait > 0) begin
                done_wait--;
                if (done_wait == 0) begin
                    sec_done_i = 1'b1;
                    check(busy_o == 1'b1, "R8 busy while commit pending", busy_o, 1);
                end
            end
            // write sink
            rcyc++;
            sec_ready_i = (rcyc % 3) != 1;
            if (sec_valid_o && sec_ready_i) begin
                logic [15:0] want;
                logic [26:0] want_lba;
                int off;
                off = sec_seen * SW + beat;
                if (exp_kind == 1 || exp_kind == 2)
                    want = eep_f(10'(off));
                else if (exp_kind == 4)
                    want = sdr_f(26'h1FF0000 + 26'(off));
                else
                    want = sdr_f(26'h1FFC000 + 26'(off));
                want_lba = tbl_f(8'(sec_seen))[26:0];
                if (sec_word_o != want) sec_bad++;
                if (sec_lba_o != want_lba) sec_bad++;
                if (sec_last_o != (beat == SW - 1)) sec_bad++;
                beat++;
                if (beat == SW) begin
                    if (exp_kind == 1 || exp_kind == 2)
                        check(sec_bad == 0, $sformatf("R4 R5 R7 sector %0d mismatches", sec_seen), sec_bad, 0);
                    else
                        check(sec_bad == 0, $sformatf("R4 R6 R7 sector %0d mismatches", sec_seen), sec_bad, 0);
                    sec_seen++;
                    beat = 0;
                    sec_bad = 0;
                    done_wait = 2;
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
            summary();
        end
    end

    task automatic run_case(input int kind, input bit dev, input bit disturb);
        int n;
        @(negedge clk);
        save_type_i = 3'(kind);
        dev_mode_i  = dev;
        exp_kind    = kind;
        n           = exp_count(kind, dev);
        exp_sect    = n;
        sec_seen    = 0;
        beat        = 0;
        sec_bad     = 0;
        repeat (2) @(negedge clk);
        nmi_i = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(busy_o == 1'b0, "R1 busy not yet high after two edges", busy_o, 0);
        @(posedge clk); @(negedge clk);
        nmi_i = 1'b0;
        if (n == 0) begin
            check(busy_o == 1'b0, $sformatf("R2 suppressed type %0d dev %0d", kind, dev), busy_o, 0);
            repeat (20) @(negedge clk);
            check(sec_seen == 0 && busy_o == 1'b0, "R2 no beats when suppressed", sec_seen, 0);
        end else begin
            check(busy_o == 1'b1, $sformatf("R1 busy after third edge type %0d", kind), busy_o, 1);
            if (disturb) begin
                repeat (50) @(negedge clk);
                nmi_i = 1'b1;
                save_type_i = 3'd1;
                dev_mode_i = 1'b1;
                repeat (4) @(negedge clk);
                nmi_i = 1'b0;
            end
            while (busy_o) @(negedge clk);
            repeat (3) @(negedge clk);
            if (disturb)
                check(sec_seen == n, "R9 run unaffected by mid-run NMI and type change", sec_seen, n);
            else
                check(sec_seen == n, $sformatf("R3 sector count type %0d", kind), sec_seen, n);
        end
        dev_mode_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 1'b0, "R10 busy in reset", busy_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 1'b0 && sec_valid_o == 1'b0 && sdr_req_o == 1'b0,
              "R10 quiet after reset", {busy_o, sec_valid_o, sdr_req_o}, 0);
        for (int d = 1; d >= 0; d--) begin
            for (int k = 0; k < 8; k++) begin
                run_case(k, d[0], 1'b0);
            end
        end
        run_case(3, 1'b0, 1'b1);
        summary();
    end
endmodule